// File: doc/BRIEF.md
# Dual-Array Memory Bus Decoder

This block is a clock-synchronous model of the front end of a part that holds a small static RAM and a one-time-programmable read-only array. Both arrays sit behind one shared address bus and one 16-bit data bus. Each cycle the block looks at two active-low chip enables, an active-low output enable, an active-low write enable and a word/byte select. From these it settles on one operating mode. It then writes the RAM, reads one of the two arrays, or leaves the bus alone. It also registers three output-drive enables: one for data pins 0 to 7, one for pins 8 to 14, and one for pin 15.

In byte organisation, pin 15 is not data. It is an extra low address bit that picks the byte lane inside a 16-bit word. So one bus serves both arrays, in either 8-bit or 16-bit organisation. The read-only array is filled with a fixed, computed pattern while reset is held. If both chip enables are asserted together, the block treats it as an illegal request: it raises a flag and suppresses every array access. All outputs are registered. The effect of the inputs sampled at one rising edge is visible right after that edge.

Top module: `dual_mem_front`

## Requirements
- R1: While reset is held, and right after it is released, all three drive enables, the data output and the conflict flag are 0.
- R2: With both enables high (standby), all three drive enables are 0 and the data output is 0 after the next edge.
- R3: A RAM word write (RAM enable low, ROM enable high, write enable low, word_mode=1) stores d_in. A later RAM word read (output enable low, write enable high) returns that word, with all three drive enables set to 1.
- R4: A read of either array with output enable high sets all drive enables to 0 and the data output to 0.
- R5: During a RAM write the output enable has no effect, and all three drive enables are 0.
- R6: A byte write (word_mode=0) changes only one lane of the addressed word. d_in[15]=1 selects bits 15:8 and d_in[15]=0 selects bits 7:0. The value written is d_in[7:0].
- R7: A RAM byte read returns the lane chosen by d_in[15] on d_out[7:0] and zero on d_out[15:8]. Only the low drive enable is set.
- R8: A ROM word read (ROM enable low, RAM enable high, output enable low) ignores write enable. It returns the word at address a, with bits 15:8 = (3a+17) mod 256 and bits 7:0 = (a XOR 0x5A) mod 256. All three drive enables are set.
- R9: A ROM byte read returns the lane chosen by d_in[15] on d_out[7:0]. Only the low drive enable is set.
- R10: When both enables are low, the conflict flag is 1 and all drive enables are 0 after the next edge, and the RAM is not written.
- R11: The RAM decodes only the low RAM_AW address bits. The ROM decodes all ROM_AW bits. With the defaults (4 and 5), addresses 3 and 19 name the same RAM word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; loads the ROM pattern |
| ram_en_n | input | 1 | Active-low RAM chip enable |
| rom_en_n | input | 1 | Active-low read-only array chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low RAM write enable |
| word_mode | input | 1 | 1 = 16-bit organisation, 0 = 8-bit organisation |
| addr | input | ROM_AW | Shared word address |
| d_in | input | 16 | Data bus as seen on the inputs; bit 15 is the byte select in 8-bit mode |
| d_out | output | 16 | Registered read data |
| oe_lo | output | 1 | Drive enable for data pins 7:0 |
| oe_mid | output | 1 | Drive enable for data pins 14:8 |
| oe_top | output | 1 | Drive enable for data pin 15 |
| conflict | output | 1 | Both chip enables were low at the last edge |

## Verification
The hardest case to reach from the ports is the illegal request that also carries a RAM write. Write enable is low and fresh data is on the bus, so the only proof that the write was blocked is a later read of that same word. The stimulus first fills the RAM with known words. It then asserts both enables with write enable low and new data, and reads the word back. It also re-reads aliased RAM addresses and single lanes after byte writes, so that a lane or address bit that leaks through shows up at the data output.

// File: rtl/dmf_pkg.sv
package dmf_pkg;

    localparam int DATA_W = 16;
    localparam int LANE_W = 8;

    typedef enum logic [2:0] {
        M_IDLE,
        M_QUIET,
        M_RAM_RD,
        M_RAM_WR,
        M_ROM_RD,
        M_CONFLICT
    } mode_e;

    typedef struct packed {
        logic [DATA_W-1:0] dout;
        logic              lo;
        logic              mid;
        logic              top;
        logic              err;
    } front_t;

endpackage

// File: rtl/dmf_mode_decode.sv
module dmf_mode_decode
    import dmf_pkg::*;
(
    input  logic  ram_en_n,
    input  logic  rom_en_n,
    input  logic  oe_n,
    input  logic  we_n,
    output mode_e mode
);

    always_comb begin
        if (!ram_en_n && !rom_en_n) begin
            mode = M_CONFLICT;
        end else if (!ram_en_n) begin
            // write has priority; output enable is ignored while writing
            if (!we_n)      mode = M_RAM_WR;
            else if (!oe_n) mode = M_RAM_RD;
            else            mode = M_QUIET;
        end else if (!rom_en_n) begin
            // write enable is ignored for the read-only array
            if (!oe_n) mode = M_ROM_RD;
            else       mode = M_QUIET;
        end else begin
            mode = M_IDLE;
        end
    end

endmodule

// File: rtl/dmf_ram_bank.sv
module dmf_ram_bank
    import dmf_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_word,
    input  logic              wr_lane,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;
    localparam int LANES = DATA_W / LANE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];
        logic              lane_hit;
        logic [LANE_W-1:0] lane_data;

        assign lane_hit  = wr_en && (wr_word || (wr_lane == 1'(g)));
        assign lane_data = wr_word ? wr_data[g*LANE_W +: LANE_W] : wr_data[LANE_W-1:0];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) lane_mem[i] <= '0;
            end else if (lane_hit) begin
                lane_mem[wr_addr] <= lane_data;
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = lane_mem[rd_addr];
    end

endmodule

// File: rtl/dmf_rom_bank.sv
module dmf_rom_bank
    import dmf_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] rom_mem [DEPTH];

    // pattern is loaded while reset is held and kept afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                rom_mem[i] <= {8'(i * 3 + 17), 8'(i ^ 32'h5A)};
            end
        end
    end

    assign rd_data = rom_mem[rd_addr];

endmodule

// File: rtl/dual_mem_front.sv
module dual_mem_front
    import dmf_pkg::*;
#(
    parameter int RAM_AW = 4,
    parameter int ROM_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ram_en_n,
    input  logic              rom_en_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              word_mode,
    input  logic [ROM_AW-1:0] addr,
    input  logic [15:0]       d_in,
    output logic [15:0]       d_out,
    output logic              oe_lo,
    output logic              oe_mid,
    output logic              oe_top,
    output logic              conflict
);

    mode_e             mode;
    logic              lane_sel;
    logic [DATA_W-1:0] ram_rd;
    logic [DATA_W-1:0] rom_rd;
    front_t            st_d, st_q;

    // in byte organisation bit 15 of the bus is the extra low address bit
    assign lane_sel = d_in[DATA_W-1];

    dmf_mode_decode u_decode (
        .ram_en_n (ram_en_n),
        .rom_en_n (rom_en_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .mode     (mode)
    );

    dmf_ram_bank #(.AW(RAM_AW)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mode == M_RAM_WR),
        .wr_word (word_mode),
        .wr_lane (lane_sel),
        .wr_addr (addr[RAM_AW-1:0]),
        .wr_data (d_in),
        .rd_addr (addr[RAM_AW-1:0]),
        .rd_data (ram_rd)
    );

    dmf_rom_bank #(.AW(ROM_AW)) u_rom (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (addr),
        .rd_data (rom_rd)
    );

    always_comb begin
        logic [DATA_W-1:0] src;
        st_d = '0;
        src  = (mode == M_ROM_RD) ? rom_rd : ram_rd;
        case (mode)
            M_RAM_RD, M_ROM_RD: begin
                st_d.lo = 1'b1;
                if (word_mode) begin
                    st_d.dout = src;
                    st_d.mid  = 1'b1;
                    st_d.top  = 1'b1;
                end else begin
                    st_d.dout = {8'h00, lane_sel ? src[15:8] : src[7:0]};
                end
            end
            M_CONFLICT: st_d.err = 1'b1;
            default:    st_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign d_out    = st_q.dout;
    assign oe_lo    = st_q.lo;
    assign oe_mid   = st_q.mid;
    assign oe_top   = st_q.top;
    assign conflict = st_q.err;

endmodule

// File: rtl/dmf_checker.sv
module dmf_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        ram_en_n,
    input logic        rom_en_n,
    input logic        oe_n,
    input logic        we_n,
    input logic        word_mode,
    input logic [15:0] d_out,
    input logic        oe_lo,
    input logic        oe_mid,
    input logic        oe_top,
    input logic        conflict
);

    logic one_read;
    assign one_read = !oe_n && (ram_en_n != rom_en_n) && (ram_en_n || we_n);

    // R2
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en_n && rom_en_n) |=> !(oe_lo || oe_mid || oe_top));

    // R10
    conflict_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_en_n && !rom_en_n) |=> (conflict && !oe_lo && !oe_mid && !oe_top));

    // R5
    write_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_en_n && !ram_en_n && !we_n) |=> !(oe_lo || oe_mid || oe_top));

    // R7
    byte_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (one_read && !word_mode) |=> (oe_lo && !oe_mid && !oe_top && d_out[15:8] == 8'h00));

    // R3
    word_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (one_read && word_mode) |=> (oe_lo && oe_mid && oe_top && !conflict));

endmodule

bind dual_mem_front dmf_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ram_en_n  (ram_en_n),
    .rom_en_n  (rom_en_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .word_mode (word_mode),
    .d_out     (d_out),
    .oe_lo     (oe_lo),
    .oe_mid    (oe_mid),
    .oe_top    (oe_top),
    .conflict  (conflict)
);

// File: tb/dual_mem_front_bench.sv
module dual_mem_front_bench;

    localparam int RAM_AW = 4;
    localparam int ROM_AW = 5;

    typedef struct {
        bit          care;
        logic [15:0] d;
        logic [2:0]  oe;
        logic        err;
        int          req;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ram_en_n = 1'b1, rom_en_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic              word_mode = 1'b1;
    logic [ROM_AW-1:0] addr = '0;
    logic [15:0]       d_in = '0;
    logic [15:0]       d_out;
    logic              oe_lo, oe_mid, oe_top, conflict;

    int   checks = 0;
    int   fails  = 0;
    exp_t sb_q[$];
    logic [15:0] ram_model [1 << RAM_AW];

    always #5 clk = ~clk;

    dual_mem_front #(.RAM_AW(RAM_AW), .ROM_AW(ROM_AW)) u_dual_mem_front (
        .clk(clk), .rst_n(rst_n), .ram_en_n(ram_en_n), .rom_en_n(rom_en_n),
        .oe_n(oe_n), .we_n(we_n), .word_mode(word_mode), .addr(addr), .d_in(d_in),
        .d_out(d_out), .oe_lo(oe_lo), .oe_mid(oe_mid), .oe_top(oe_top), .conflict(conflict)
    );

    function automatic logic [15:0] rom_word(int a);
        return {8'(a * 3 + 17), 8'(a ^ 32'h5A)};
    endfunction

    task automatic compare(int req, logic [15:0] d, logic [2:0] oe, logic err);
        checks++;
        if (d_out !== d || {oe_lo, oe_mid, oe_top} !== oe || conflict !== err) begin
            fails++;
            $display("FAIL R%0d: got d=%h oe=%b err=%b, expected d=%h oe=%b err=%b",
                     req, d_out, {oe_lo, oe_mid, oe_top}, conflict, d, oe, err);
        end
    endtask

    // monitor: one expected item per registered cycle
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            if (e.care) compare(e.req, e.d, e.oe, e.err);
        end
    end

    task automatic drive(logic rn, logic on, logic oe, logic we, logic wm,
                         int a, logic [15:0] din,
                         logic [15:0] ed, logic [2:0] eoe, logic eerr, int req);
        exp_t e;
        @(negedge clk);
        ram_en_n = rn; rom_en_n = on; oe_n = oe; we_n = we; word_mode = wm;
        addr = ROM_AW'(a); d_in = din;
        e.care = 1'b1; e.d = ed; e.oe = eoe; e.err = eerr; e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic ram_write(logic wm, logic oe, int a, logic [15:0] din, int req);
        int w = a % (1 << RAM_AW);
        if (wm) ram_model[w] = din;
        else if (din[15]) ram_model[w][15:8] = din[7:0];
        else ram_model[w][7:0] = din[7:0];
        drive(1'b1, 1'b1, oe, 1'b0, wm, a, din, 16'h0, 3'b000, 1'b0, req);
        ram_en_n = 1'b0; // RAM enable low for the write
    endtask

    task automatic ram_read(logic wm, int a, logic lane, int req);
        logic [15:0] w = ram_model[a % (1 << RAM_AW)];
        if (wm) drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, a, 16'h0, w, 3'b111, 1'b0, req);
        else drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, a, {lane, 15'h0},
                   {8'h00, lane ? w[15:8] : w[7:0]}, 3'b100, 1'b0, req);
    endtask

    task automatic rom_read(logic wm, int a, logic lane, logic we, int req);
        logic [15:0] w = rom_word(a);
        if (wm) drive(1'b1, 1'b0, 1'b0, we, 1'b1, a, 16'h0, w, 3'b111, 1'b0, req);
        else drive(1'b1, 1'b0, 1'b0, we, 1'b0, a, {lane, 15'h0},
                   {8'h00, lane ? w[15:8] : w[7:0]}, 3'b100, 1'b0, req);
    endtask

    initial begin
        #2_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog: got no end, expected end of run");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < (1 << RAM_AW); i++) ram_model[i] = 16'h0;
        repeat (3) @(posedge clk);
        #2;
        compare(1, 16'h0, 3'b000, 1'b0); // R1 during reset
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        compare(1, 16'h0, 3'b000, 1'b0); // R1 after release

        // R2 standby
        drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4, 16'hFFFF, 16'h0, 3'b000, 1'b0, 2);

        // R3 / R5: word writes with output enable toggling
        for (int i = 0; i < 16; i++) begin
            ram_write(1'b1, 1'(i), i, 16'h1000 + 16'(i * 16'h0111) ^ 16'hA5C3, 5);
        end
        for (int i = 0; i < 16; i++) ram_read(1'b1, i, 1'b0, 3);

        // R4 read with output enable high
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2, 16'h0, 16'h0, 3'b000, 1'b0, 4);
        drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2, 16'h0, 16'h0, 3'b000, 1'b0, 4);

        // R6 byte writes touch one lane only; bits 14:8 of the bus are junk
        ram_write(1'b0, 1'b1, 2, 16'hFFC3, 6);
        ram_write(1'b0, 1'b0, 5, 16'h7E3C, 6);
        ram_read(1'b1, 2, 1'b0, 6);
        ram_read(1'b1, 5, 1'b0, 6);

        // R7 byte reads of both lanes
        ram_read(1'b0, 2, 1'b1, 7);
        ram_read(1'b0, 2, 1'b0, 7);
        ram_read(1'b0, 9, 1'b1, 7);
        ram_read(1'b0, 5, 1'b0, 7);

        // R8 ROM word reads, write enable both ways
        rom_read(1'b1, 0, 1'b0, 1'b1, 8);
        rom_read(1'b1, 17, 1'b0, 1'b0, 8);
        rom_read(1'b1, 31, 1'b0, 1'b0, 8);

        // R9 ROM byte reads
        rom_read(1'b0, 6, 1'b1, 1'b1, 9);
        rom_read(1'b0, 6, 1'b0, 1'b0, 9);
        rom_read(1'b0, 30, 1'b1, 1'b1, 9);

        // R10 illegal request carrying a write, then read back
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 7, 16'hDEAD, 16'h0, 3'b000, 1'b1, 10);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 7, 16'h80EE, 16'h0, 3'b000, 1'b1, 10);
        ram_read(1'b1, 7, 1'b0, 10);

        // R11 RAM address aliasing
        ram_write(1'b1, 1'b1, 19, 16'h5AA5, 11);
        ram_read(1'b1, 3, 1'b0, 11);
        ram_read(1'b1, 19, 1'b0, 11);

        drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 0, 16'h0, 16'h0, 3'b000, 1'b0, 2);
        repeat (3) @(posedge clk);
        #3;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule